// File: doc/BRIEF.md
# Real-time clock seconds core with alarm

This block keeps wall-clock time as a plain count of seconds. It runs from a slow reference clock. A programmable divider turns that clock into one tick per second, and each tick advances a 32-bit seconds counter. Each tick also raises a tick flag. A compare unit raises an alarm flag when the count reaches a programmed alarm value. Either flag can drive a single interrupt line, and each flag has its own enable.

Software reaches the block through a 32-bit register port with a single-cycle write strobe and a combinational read path. The port holds five registers. The control register (offset 0x00) has the run switch, the alarm enable, the two interrupt enables, the two flags and a write-ready indication. The seconds register sits at 0x04, the alarm value at 0x08 and the divider value at 0x0C. A free scratch word at 0x34 is never touched by the hardware. Boot code can store a marker there, such as 0x12345678, and check it later to learn whether the kept time is still trustworthy.

Top module: `rtcs_top`

## Requirements
- R1: After reset, control reads 0x80, and seconds, alarm and scratch read 0. The divider reads its reset parameter (default 32767), and irq is 0.
- R2: With run set and divider value P, seconds rises by one every P+1 clock cycles. The first step comes P+1 cycles after the last write to the seconds or divider register, because such a write restarts the divider phase.
- R3: While run (control bit 0) is 0, the seconds count and the divider phase both hold. After run is set again, counting resumes from the held phase.
- R4: A write to seconds loads the written value. The count wraps from 0xFFFFFFFF to 0.
- R5: Each tick sets the tick flag (control bit 6). Writing 0 to that bit clears it and writing 1 keeps it. A tick in the same cycle as a clearing write leaves the flag set.
- R6: When alarm enable (bit 2) is 1, the alarm flag (bit 4) is set one cycle after the count becomes equal to the alarm register. It is set only once per match. It is never set while alarm enable is 0, and it is cleared by writing 0 to bit 4.
- R7: irq is 1 exactly when the tick flag and tick interrupt enable (bit 5) are both set, or when the alarm flag and alarm interrupt enable (bit 3) are both set.
- R8: The scratch register keeps any written value. Offsets outside the five registers read 0, and writes to them change nothing.
- R9: Control bit 7 (write ready) always reads 1, and writes to it are ignored.
- R10: Control bits 0, 2, 3 and 5 read back as last written. Bit 1 and bits above 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data (combinational from reg_addr) |
| irq | output | 1 | Interrupt request, level |

## Verification
The counter is first driven with run off and then with run on, using a five-cycle second. Reads are placed on the cycle before and the cycle after each expected step, so a divider that is off by one shows up. A load next to the 32-bit limit shows whether the counter wraps. A pause-and-resume sequence, followed by a switch to a two-cycle divider, shows whether the phase is held or restarted. The flag logic is tried with a write that keeps the tick flag, a clearing write timed on a tick edge, and a plain clearing write. The alarm is tried with the enable on, then with the count still matching after a clear, and then with the enable off, which separates edge-triggered, level-triggered and ungated compares.

// File: rtl/rtcs_pkg.sv
`timescale 1ns/1ps
// Shared constants of the seconds core: register offsets, control bit
// positions and the index of each register in the decode tables.
package rtcs_pkg;

    // Number of registers in the map.
    localparam int NREG = 5;

    // Table index of each register.
    localparam int IDX_CTRL = 0;
    localparam int IDX_SECS = 1;
    localparam int IDX_ALRM = 2;
    localparam int IDX_DIV  = 3;
    localparam int IDX_SCR  = 4;

    // Byte offsets, in table-index order.
    localparam logic [7:0] REG_OFS [NREG] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h34};

    // Control register bit positions. Driver software depends on these.
    localparam int B_RUN    = 0;
    localparam int B_ALM_EN = 2;
    localparam int B_ALM_IE = 3;
    localparam int B_ALM_F  = 4;
    localparam int B_TCK_IE = 5;
    localparam int B_TCK_F  = 6;
    localparam int B_WRDY   = 7;

endpackage

// File: rtl/rtcs_prescaler.sv
`timescale 1ns/1ps
// Reference-clock divider. It makes a one-cycle tick every (limit+1) cycles
// in which run is high.
// Assumes: restart has priority and suppresses the tick in its cycle. A limit
// lowered below the current phase gives a tick on the next run cycle.
module rtcs_prescaler #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;

    // The tick fires when the phase has reached the programmed limit.
    assign tick = run && !restart && (phase_q >= limit);

    // Phase register: cleared on restart or tick, held while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || tick) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtcs_counter.sv
`timescale 1ns/1ps
// Seconds counter. It loads from the register port and otherwise steps by
// one on each tick, wrapping at its width.
// Assumes: load and tick never need to combine; load wins.
module rtcs_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    assign count = count_q;

    // Count register: software load first, then tick increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtcs_events.sv
`timescale 1ns/1ps
// Event flags. The tick flag is set by each tick. The alarm flag is set on
// the first cycle in which the enabled compare matches. A control write
// clears a flag when its keep bit is 0.
// Assumes: alm_eq is a plain equality from the same clock domain. In the
// same cycle, a set always wins over a clear.
module rtcs_events (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic alm_en,
    input  logic alm_eq,
    input  logic ctl_wr,
    input  logic keep_tck,
    input  logic keep_alm,
    output logic tck_flag,
    output logic alm_flag
);

    logic match_q;
    logic alm_set;

    // The alarm event is the rising edge of the enabled compare.
    assign alm_set = alm_en && alm_eq && !match_q;

    // Remembers last cycle's enabled compare, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= alm_en && alm_eq;
        end
    end

    // Tick flag: set by a tick, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck_flag <= 1'b0;
        end else if (tick) begin
            tck_flag <= 1'b1;
        end else if (ctl_wr && !keep_tck) begin
            tck_flag <= 1'b0;
        end
    end

    // Alarm flag: set by a compare edge, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_flag <= 1'b0;
        end else if (alm_set) begin
            alm_flag <= 1'b1;
        end else if (ctl_wr && !keep_alm) begin
            alm_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rtcs_top.sv
`timescale 1ns/1ps
// Seconds core top. It holds the register file and decodes the register
// port, and it wires together the divider, the counter and the event flags.
// Assumes: single-cycle writes qualified by reg_sel and reg_wr; reads are a
// combinational function of reg_addr; REG_W is at least 8 and ADDR_W at
// least 6.
module rtcs_top
    import rtcs_pkg::*;
#(
    parameter int          REG_W     = 32,
    parameter int          DIV_W     = 32,
    parameter int          ADDR_W    = 8,
    parameter int unsigned DIV_RESET = 32767
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);

    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

    // Decode vectors: address hit, and write strobe for each register.
    logic [NREG-1:0] hit;
    logic [NREG-1:0] wsel;

    // Control-register state.
    logic run_q;
    logic alm_en_q;
    logic alm_ie_q;
    logic tck_ie_q;

    // Plain storage registers.
    logic [REG_W-1:0] alarm_q;
    logic [REG_W-1:0] scratch_q;
    logic [DIV_W-1:0] div_q;

    // Signals between the sub-blocks.
    logic             tick;
    logic             secs_wr;
    logic             div_wr;
    logic             ctl_wr;
    logic             restart;
    logic [REG_W-1:0] secs_q;
    logic             tck_flag;
    logic             alm_flag;
    logic [REG_W-1:0] ctrl_rd;
    logic [REG_W-1:0] reg_val [NREG];

    // Address decode, one comparator per register.
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit[g]  = (reg_addr == ADDR_W'(REG_OFS[g]));
        assign wsel[g] = reg_sel && reg_wr && hit[g];
    end

    assign ctl_wr  = wsel[IDX_CTRL];
    assign secs_wr = wsel[IDX_SECS];
    assign div_wr  = wsel[IDX_DIV];
    // Loading the time or changing the rate starts a fresh second.
    assign restart = secs_wr || div_wr;

    // Control enables: written directly from the data bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            alm_en_q <= 1'b0;
            alm_ie_q <= 1'b0;
            tck_ie_q <= 1'b0;
        end else if (ctl_wr) begin
            run_q    <= reg_wdata[B_RUN];
            alm_en_q <= reg_wdata[B_ALM_EN];
            alm_ie_q <= reg_wdata[B_ALM_IE];
            tck_ie_q <= reg_wdata[B_TCK_IE];
        end
    end

    // Alarm compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else if (wsel[IDX_ALRM]) begin
            alarm_q <= reg_wdata;
        end
    end

    // Divider limit: reference cycles per second, minus one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_INIT;
        end else if (div_wr) begin
            div_q <= reg_wdata[DIV_W-1:0];
        end
    end

    // Scratch word, free for software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
        end else if (wsel[IDX_SCR]) begin
            scratch_q <= reg_wdata;
        end
    end

    rtcs_prescaler #(
        .DIV_W (DIV_W)
    ) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (restart),
        .limit   (div_q),
        .tick    (tick)
    );

    rtcs_counter #(
        .CNT_W (REG_W)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (secs_wr),
        .load_val (reg_wdata),
        .count    (secs_q)
    );

    rtcs_events i_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .alm_en   (alm_en_q),
        .alm_eq   (secs_q == alarm_q),
        .ctl_wr   (ctl_wr),
        .keep_tck (reg_wdata[B_TCK_F]),
        .keep_alm (reg_wdata[B_ALM_F]),
        .tck_flag (tck_flag),
        .alm_flag (alm_flag)
    );

    // Control read image: enables, flags and the constant ready bit.
    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[B_RUN]    = run_q;
        ctrl_rd[B_ALM_EN] = alm_en_q;
        ctrl_rd[B_ALM_IE] = alm_ie_q;
        ctrl_rd[B_ALM_F]  = alm_flag;
        ctrl_rd[B_TCK_IE] = tck_ie_q;
        ctrl_rd[B_TCK_F]  = tck_flag;
        ctrl_rd[B_WRDY]   = 1'b1;
    end

    // Read sources, in table-index order.
    always_comb begin
        reg_val[IDX_CTRL] = ctrl_rd;
        reg_val[IDX_SECS] = secs_q;
        reg_val[IDX_ALRM] = alarm_q;
        reg_val[IDX_DIV]  = REG_W'(div_q);
        reg_val[IDX_SCR]  = scratch_q;
    end

    // Read mux: OR of the selected sources; an unmapped offset gives zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                reg_rdata = reg_rdata | reg_val[i];
            end
        end
    end

    // Interrupt: each flag gated by its own enable.
    assign irq = (tck_flag && tck_ie_q) || (alm_flag && alm_ie_q);

endmodule

// File: rtl/rtcs_top_chk.sv
`timescale 1ns/1ps
// Property checker for rtcs_top, attached by the bind at the end of this
// file. It watches the divider tick, the count, the flags and the read port.
module rtcs_top_chk
    import rtcs_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              run,
    input logic              secs_wr,
    input logic [REG_W-1:0]  secs,
    input logic              tck_flag,
    input logic              alm_flag,
    input logic              alm_en,
    input logic              irq,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_rdata
);

    // R2 / R4: a tick steps the count by exactly one, wrapping at the width.
    a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (secs == REG_W'($past(secs) + 1'b1)));

    // R3: when stopped and not loaded, the count does not move.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !secs_wr) |=> $stable(secs));

    // R5: a tick always leaves the tick flag set.
    a_r5_tick_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> tck_flag);

    // R6: the alarm flag only rises if alarm enable was on.
    a_r6_alarm_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(alm_en));

    // R7: no interrupt without a pending flag.
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tck_flag || alm_flag));

    // R9: the control image always shows write ready.
    a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(REG_OFS[IDX_CTRL])) |-> reg_rdata[B_WRDY]);

endmodule

bind rtcs_top rtcs_top_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (run_q),
    .secs_wr   (secs_wr),
    .secs      (secs_q),
    .tck_flag  (tck_flag),
    .alm_flag  (alm_flag),
    .alm_en    (alm_en_q),
    .irq       (irq),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/test_rtcs_top.sv
`timescale 1ns/1ps
// Scoreboard bench. Driver tasks push expected values into queues, and a
// monitor pops and compares them one time unit after each falling edge.
// Every bus operation takes one cycle. A write at operation j is seen by a
// read at operation j+1. Counter j is the number of operations since the
// last seconds or divider write.
module test_rtcs_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_sel;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    int    j = 0;
    bit    done = 1'b0;
    bit    q_kind [$];
    logic [31:0] q_exp [$];
    string q_tag [$];

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_SECS = 8'h04;
    localparam logic [7:0] A_ALRM = 8'h08;
    localparam logic [7:0] A_DIV  = 8'h0C;
    localparam logic [7:0] A_SCR  = 8'h34;
    localparam logic [7:0] A_NONE = 8'h50;

    always #2.5 clk = ~clk;

    rtcs_top i_rtcs_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic op_begin();
        @(negedge clk);
        j = j + 1;
    endtask

    task automatic idle();
        op_begin();
        reg_sel = 1'b0;
        reg_wr  = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        op_begin();
        reg_sel   = 1'b1;
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        if (a == A_SECS || a == A_DIV) j = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        op_begin();
        reg_sel  = 1'b1;
        reg_wr   = 1'b0;
        reg_addr = a;
        q_kind.push_back(1'b0);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // Adds an irq check to the current operation, without using a cycle.
    task automatic chk_irq(input logic e, input string tag);
        q_kind.push_back(1'b1);
        q_exp.push_back({31'b0, e});
        q_tag.push_back(tag);
    endtask

    // Idles until the next operation will be number t.
    task automatic wait_to(input int t);
        while (j < t - 1) idle();
    endtask

    // Monitor: compares queued expectations against the ports.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_exp.size() > 0) begin
                bit          k;
                logic [31:0] e;
                logic [31:0] act;
                string       t;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                act = k ? {31'b0, irq} : reg_rdata;
                checks++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, act, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 and R9: reset image.
        rd(A_CTRL, 32'h80, "R1 ctrl reset / R9 ready");
        chk_irq(1'b0, "R1 irq reset");
        rd(A_SECS, 32'd0, "R1 seconds reset");
        rd(A_DIV, 32'd32767, "R1 divider reset");
        rd(A_ALRM, 32'd0, "R1 alarm reset");
        rd(A_SCR, 32'd0, "R1 scratch reset");

        // R8: scratch storage, and unmapped offsets.
        wr(A_SCR, 32'h12345678);
        rd(A_SCR, 32'h12345678, "R8 scratch write");
        wr(A_NONE, 32'hFFFF_FFFF);
        rd(A_NONE, 32'd0, "R8 unmapped reads zero");
        rd(A_SCR, 32'h12345678, "R8 unmapped write ignored (scratch)");
        rd(A_ALRM, 32'd0, "R8 unmapped write ignored (alarm)");

        // R10 and R9: enable readback; bit 1 and bit 7 are not writable.
        wr(A_CTRL, 32'h0000_002E);
        rd(A_CTRL, 32'hAC, "R10 enable readback");
        wr(A_CTRL, 32'h0000_0000);
        rd(A_CTRL, 32'h80, "R9 ready kept after writing 0");

        // R3: stopped, so the count holds.
        wr(A_DIV, 32'd4);
        wr(A_SECS, 32'd50);
        wait_to(10);
        rd(A_SECS, 32'd50, "R3 stopped count holds");
        wr(A_CTRL, 32'h01);

        // R2: five-cycle second. A read at op j sees 100 + (j-1)/5.
        wr(A_SECS, 32'd100);
        wait_to(5);
        rd(A_SECS, 32'd100, "R2 before first step");
        rd(A_SECS, 32'd101, "R2 first step");
        rd(A_CTRL, 32'hC1, "R5 tick flag set");
        chk_irq(1'b0, "R7 tick flag without enable");
        wr(A_CTRL, 32'h61);
        rd(A_CTRL, 32'hE1, "R5 write 1 keeps flag");
        chk_irq(1'b1, "R7 tick interrupt");
        wr(A_CTRL, 32'h21);
        rd(A_CTRL, 32'hE1, "R5 tick beats clear");
        wr(A_CTRL, 32'h21);
        rd(A_CTRL, 32'hA1, "R5 write 0 clears flag");
        chk_irq(1'b0, "R7 irq drops with flag");

        // R6: alarm at 104 is reached at E20, and the flag rises at E21.
        wr(A_ALRM, 32'd104);
        wait_to(16);
        wr(A_CTRL, 32'h4D);
        wait_to(21);
        rd(A_CTRL, 32'hCD, "R6 no flag on match cycle");
        chk_irq(1'b0, "R7 no alarm yet");
        rd(A_CTRL, 32'hDD, "R6 alarm flag set");
        chk_irq(1'b1, "R7 alarm interrupt");
        rd(A_SECS, 32'd104, "R6 count at alarm");
        wr(A_CTRL, 32'h4D);
        rd(A_CTRL, 32'hCD, "R6 no re-set while still matching");
        chk_irq(1'b0, "R7 irq after alarm clear");
        wr(A_ALRM, 32'd106);
        wr(A_CTRL, 32'h49);
        wait_to(32);
        rd(A_CTRL, 32'hC9, "R6 no flag with alarm enable off");
        rd(A_SECS, 32'd106, "R6 count passed disabled alarm");

        // R4: wrap from the top of the range.
        wait_to(34);
        wr(A_SECS, 32'hFFFF_FFFF);
        wait_to(5);
        rd(A_SECS, 32'hFFFF_FFFF, "R4 load at limit");
        rd(A_SECS, 32'd0, "R4 wrap to zero");

        // R3: stop at E7 with the phase at 2, resume at E21, step at E24.
        wr(A_CTRL, 32'h48);
        wait_to(20);
        rd(A_SECS, 32'd0, "R3 hold while stopped");
        wr(A_CTRL, 32'h49);
        wait_to(24);
        rd(A_SECS, 32'd0, "R3 phase resumes, not yet");
        rd(A_SECS, 32'd1, "R3 phase resumes, step");

        // R2: a divider write restarts the phase; now a two-cycle second.
        wr(A_DIV, 32'd1);
        rd(A_DIV, 32'd1, "R2 divider readback");
        rd(A_SECS, 32'd1, "R2 restart, not yet");
        rd(A_SECS, 32'd2, "R2 restart, first step");
        wait_to(5);
        rd(A_SECS, 32'd3, "R2 two-cycle second");

        idle();
        idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule